// File: doc/BRIEF.md
# Cartridge Bus Unlocked Configuration Register File

This block watches the 16-bit write traffic of a cartridge-style address/data bus. Its configuration registers are shut by default. They open only after four writes arrive back to back, each with one fixed address and one fixed data value, in one fixed order. While the window is open, any number of writes land in a bank of twelve registers. The registers set storage-card control, data-buffer control, SPI enable and SPI write enable, real-time-clock enable and auto-save mode. They also hold the ROM, PSRAM and RAM page numbers, a 32-bit sector address split into two halves, and a transfer block count. One separate address/data pair closes the window again.

Every register value drives an output. The storage-card control word is also decoded into an enabled flag and a read-state flag. Each accepted write of the block-count register sends a one-cycle start pulse to the transfer engine next door. The pulse carries the direction and the number of 512-byte sectors, limited to four.

Top module: `cbr_regfile`

## Requirements
- R1: On reset every register output is zero, `unlocked` is low and `start_pulse`, `start_write` and `start_blocks` are zero.
- R2: The four bus writes 0xD200 to 0x9FE0000, 0x1500 to 0x8000000, 0xD200 to 0x8020000 and 0x1500 to 0x8040000 (byte addresses), on consecutive write cycles and in this order, set `unlocked` high. It becomes visible in the cycle after the fourth write.
- R3: A write that does not match the next expected step sends the detector back to the first step. If that write equals the first step, it counts as the first step, so the next write is compared with step two.
- R4: While `unlocked` is low, no write changes any register.
- R5: While `unlocked` is high, a write to a register address stores the data in that register, and the output shows it one cycle later. Any number of such writes is accepted. The map is: card control 0x9400000, buffer control 0x9420000, sector address low 0x9600000, sector address high 0x9620000, block count 0x9640000, SPI enable 0x9660000, SPI write enable 0x9680000, RTC control 0x96A0000, auto-save 0x96C0000, PSRAM page 0x9860000, ROM page 0x9880000 and RAM page 0x9C00000.
- R6: Writing 0x1500 to 0x9FC0000 clears `unlocked` from the next cycle on, and later register writes are ignored. Any other data at that address leaves the state unchanged.
- R7: `sector_addr` is the high-half register in bits 31:16 and the low-half register in bits 15:0.
- R8: An accepted block-count write makes `start_pulse` high for exactly the following cycle. In that cycle `start_write` equals data bit 15, and `start_blocks` equals the lower of data bits 14:0 and 4. Outside the pulse both fields are zero.
- R9: `card_on` is high when the card control register holds 1 or 3. `card_read_state` is high only when it holds 3. Any other value drives both low.
- R10: While unlocked, a write to an address outside the map changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write qualifier, one write per cycle |
| wr_addr | input | ADDR_W | Bus byte address |
| wr_data | input | DATA_W | Bus write data |
| unlocked | output | 1 | Register window open |
| card_ctrl | output | DATA_W | Storage-card control register |
| card_on | output | 1 | Card enabled (value 1 or 3) |
| card_read_state | output | 1 | Card in read state (value 3) |
| buf_ctrl | output | DATA_W | Buffer control register |
| sector_addr | output | 2*DATA_W | Transfer sector address {high, low} |
| block_ctrl | output | DATA_W | Raw block-count register |
| spi_ctrl | output | DATA_W | SPI enable register |
| spi_wr_ctrl | output | DATA_W | SPI write enable register |
| rtc_ctrl | output | DATA_W | RTC control register |
| autosave_ctrl | output | DATA_W | Auto-save mode register |
| rom_page | output | DATA_W | ROM page select |
| psram_page | output | DATA_W | PSRAM page select |
| ram_page | output | DATA_W | RAM page select |
| start_pulse | output | 1 | One-cycle transfer start |
| start_write | output | 1 | Direction of the started transfer, 1 = write |
| start_blocks | output | BLK_W | Sector count of the started transfer, at most MAX_BLOCKS |

## Verification
The bench aims at a broken unlock order whose breaking write is itself the first step. A detector that simply returned to step one would then need one write too many and stay locked. It also checks that a write to the lock address with the wrong data does not close the window, and that a locked register write is dropped. A design that decoded the address alone would change a page register there. Block counts above four and counts with bit 15 set show up as a wrong `start_blocks` or a wrong direction. Back-to-back count writes show whether the pulse follows each accepted write rather than an edge.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam int NUM_REGS = 12;
  localparam int SEQ_LEN  = 4;

  localparam int SLOT_CARD     = 0;
  localparam int SLOT_BUF      = 1;
  localparam int SLOT_SECT_LO  = 2;
  localparam int SLOT_SECT_HI  = 3;
  localparam int SLOT_BLKS     = 4;
  localparam int SLOT_SPI      = 5;
  localparam int SLOT_SPI_WR   = 6;
  localparam int SLOT_RTC      = 7;
  localparam int SLOT_AUTOSAVE = 8;
  localparam int SLOT_PSRAM_PG = 9;
  localparam int SLOT_ROM_PG   = 10;
  localparam int SLOT_RAM_PG   = 11;

  localparam logic [31:0] LOCK_ADDR = 32'h09FC_0000;
  localparam logic [15:0] LOCK_DATA = 16'h1500;

  // address of each register slot
  function automatic logic [31:0] slot_addr(input int unsigned s);
    case (s)
      0:       return 32'h0940_0000;
      1:       return 32'h0942_0000;
      2:       return 32'h0960_0000;
      3:       return 32'h0962_0000;
      4:       return 32'h0964_0000;
      5:       return 32'h0966_0000;
      6:       return 32'h0968_0000;
      7:       return 32'h096A_0000;
      8:       return 32'h096C_0000;
      9:       return 32'h0986_0000;
      10:      return 32'h0988_0000;
      11:      return 32'h09C0_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // unlock handshake, address per step (order is behaviour)
  function automatic logic [31:0] seq_addr(input int unsigned s);
    case (s)
      0:       return 32'h09FE_0000;
      1:       return 32'h0800_0000;
      2:       return 32'h0802_0000;
      default: return 32'h0804_0000;
    endcase
  endfunction

  function automatic logic [15:0] seq_data(input int unsigned s);
    return (s[0] == 1'b0) ? 16'hD200 : 16'h1500;
  endfunction

  // sector count carried by a start pulse
  function automatic int unsigned clamp_blocks(input logic [14:0] cnt,
                                               input int unsigned lim);
    int unsigned c;
    c = 32'(cnt);
    return (c > lim) ? lim : c;
  endfunction

  function automatic logic card_is_on(input logic [15:0] v);
    return (v == 16'd1) || (v == 16'd3);
  endfunction

  function automatic logic card_is_reading(input logic [15:0] v);
    return v == 16'd3;
  endfunction

endpackage

// File: rtl/cbr_unlock_seq.sv
module cbr_unlock_seq
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              unlocked
);

  localparam int STEP_W = $clog2(SEQ_LEN);

  logic [STEP_W-1:0] step_q, step_d;
  logic [31:0]       addr_ext;
  logic              match_cur, match_first, last_step, seq_done, lock_hit;

  assign addr_ext    = 32'(wr_addr);
  assign match_cur   = wr_en && (addr_ext == seq_addr(32'(step_q)))
                       && (wr_data == DATA_W'(seq_data(32'(step_q))));
  assign match_first = wr_en && (addr_ext == seq_addr(0))
                       && (wr_data == DATA_W'(seq_data(0)));
  assign last_step   = (step_q == STEP_W'(SEQ_LEN - 1));
  assign seq_done    = match_cur && last_step;
  assign lock_hit    = wr_en && (addr_ext == LOCK_ADDR)
                       && (wr_data == DATA_W'(LOCK_DATA));

  always_comb begin
    step_d = step_q;
    if (wr_en) begin
      if (match_cur)        step_d = last_step ? '0 : step_q + STEP_W'(1);
      else if (match_first) step_d = STEP_W'(1);
      else                  step_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= '0;
      unlocked <= 1'b0;
    end else begin
      step_q <= step_d;
      if (lock_hit)      unlocked <= 1'b0;
      else if (seq_done) unlocked <= 1'b1;
    end
  end

  assert_seq_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> unlocked);

  assert_open_needs_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(seq_done));

  assert_break_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !match_cur && !match_first) |=> (step_q == '0));

  assert_lock_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> !unlocked);

endmodule

// File: rtl/cbr_addr_decode.sv
module cbr_addr_decode
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                unlocked,
  output logic [NUM_REGS-1:0] wr_sel
);

  logic [31:0]         addr_ext;
  logic [NUM_REGS-1:0] hit;

  assign addr_ext = 32'(wr_addr);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    assign hit[i] = wr_en && (addr_ext == slot_addr(i));
  end

  assign wr_sel = unlocked ? hit : '0;

endmodule

// File: rtl/cbr_reg_bank.sv
module cbr_reg_bank
  import cbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_sel[i]) regs[i] <= wr_data;
      end
    end
  end

  assert_hold_unselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == '0) |=> $stable(regs));

  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

endmodule

// File: rtl/cbr_start_gen.sv
module cbr_start_gen
  import cbr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MAX_BLOCKS = 4,
  parameter int BLK_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              start_pulse,
  output logic              start_write,
  output logic [BLK_W-1:0]  start_blocks
);

  logic [14:0] cnt_field;
  assign cnt_field = 15'(wr_data[DATA_W-2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pulse  <= 1'b0;
      start_write  <= 1'b0;
      start_blocks <= '0;
    end else begin
      start_pulse  <= count_wr;
      start_write  <= count_wr && wr_data[DATA_W-1];
      start_blocks <= count_wr ? BLK_W'(clamp_blocks(cnt_field, MAX_BLOCKS)) : '0;
    end
  end

  assert_pulse_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(count_wr));

  assert_blocks_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (start_blocks <= BLK_W'(MAX_BLOCKS)));

  assert_quiet_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |-> (!start_write && start_blocks == '0));

endmodule

// File: rtl/cbr_regfile.sv
module cbr_regfile
  import cbr_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int DATA_W     = 16,
  parameter int MAX_BLOCKS = 4,
  parameter int BLK_W      = $clog2(MAX_BLOCKS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                unlocked,
  output logic [DATA_W-1:0]   card_ctrl,
  output logic                card_on,
  output logic                card_read_state,
  output logic [DATA_W-1:0]   buf_ctrl,
  output logic [2*DATA_W-1:0] sector_addr,
  output logic [DATA_W-1:0]   block_ctrl,
  output logic [DATA_W-1:0]   spi_ctrl,
  output logic [DATA_W-1:0]   spi_wr_ctrl,
  output logic [DATA_W-1:0]   rtc_ctrl,
  output logic [DATA_W-1:0]   autosave_ctrl,
  output logic [DATA_W-1:0]   rom_page,
  output logic [DATA_W-1:0]   psram_page,
  output logic [DATA_W-1:0]   ram_page,
  output logic                start_pulse,
  output logic                start_write,
  output logic [BLK_W-1:0]    start_blocks
);

  logic [NUM_REGS-1:0]             wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            count_wr;

  cbr_unlock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .unlocked (unlocked)
  );

  cbr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .unlocked (unlocked),
    .wr_sel   (wr_sel)
  );

  cbr_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs    (regs)
  );

  assign count_wr = wr_sel[SLOT_BLKS];

  cbr_start_gen #(.DATA_W(DATA_W), .MAX_BLOCKS(MAX_BLOCKS), .BLK_W(BLK_W)) u_start (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_wr     (count_wr),
    .wr_data      (wr_data),
    .start_pulse  (start_pulse),
    .start_write  (start_write),
    .start_blocks (start_blocks)
  );

  assign card_ctrl       = regs[SLOT_CARD];
  assign card_on         = card_is_on(16'(regs[SLOT_CARD]));
  assign card_read_state = card_is_reading(16'(regs[SLOT_CARD]));
  assign buf_ctrl        = regs[SLOT_BUF];
  assign sector_addr     = {regs[SLOT_SECT_HI], regs[SLOT_SECT_LO]};
  assign block_ctrl      = regs[SLOT_BLKS];
  assign spi_ctrl        = regs[SLOT_SPI];
  assign spi_wr_ctrl     = regs[SLOT_SPI_WR];
  assign rtc_ctrl        = regs[SLOT_RTC];
  assign autosave_ctrl   = regs[SLOT_AUTOSAVE];
  assign rom_page        = regs[SLOT_ROM_PG];
  assign psram_page      = regs[SLOT_PSRAM_PG];
  assign ram_page        = regs[SLOT_RAM_PG];

  assert_locked_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(regs));

  assert_read_implies_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    card_read_state |-> card_on);

  assert_start_only_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(unlocked));

endmodule

// File: tb/cbr_regfile_bench.sv
module cbr_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [27:0] wr_addr = '0;
  logic [15:0] wr_data = '0;

  logic        unlocked, card_on, card_read_state;
  logic [15:0] card_ctrl, buf_ctrl, block_ctrl, spi_ctrl, spi_wr_ctrl;
  logic [15:0] rtc_ctrl, autosave_ctrl, rom_page, psram_page, ram_page;
  logic [31:0] sector_addr;
  logic        start_pulse, start_write;
  logic [BLK_W-1:0] start_blocks;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_regfile u_cbr_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .unlocked(unlocked), .card_ctrl(card_ctrl), .card_on(card_on),
    .card_read_state(card_read_state), .buf_ctrl(buf_ctrl), .sector_addr(sector_addr),
    .block_ctrl(block_ctrl), .spi_ctrl(spi_ctrl), .spi_wr_ctrl(spi_wr_ctrl),
    .rtc_ctrl(rtc_ctrl), .autosave_ctrl(autosave_ctrl), .rom_page(rom_page),
    .psram_page(psram_page), .ram_page(ram_page), .start_pulse(start_pulse),
    .start_write(start_write), .start_blocks(start_blocks)
  );

  // bench model: slots in the bench's own order
  // 0 card,1 buf,2 lo,3 hi,4 count,5 spi,6 spiwr,7 rtc,8 auto,9 rom,10 psram,11 ram
  logic [15:0] m_reg [12];
  int          m_step;
  bit          m_unl, m_pulse, m_dir;
  int          m_blk;

  function automatic int slot_of(input logic [27:0] a);
    case (a)
      28'h9400000: return 0;
      28'h9420000: return 1;
      28'h9600000: return 2;
      28'h9620000: return 3;
      28'h9640000: return 4;
      28'h9660000: return 5;
      28'h9680000: return 6;
      28'h96A0000: return 7;
      28'h96C0000: return 8;
      28'h9880000: return 9;
      28'h9860000: return 10;
      28'h9C00000: return 11;
      default:     return -1;
    endcase
  endfunction

  function automatic logic [27:0] addr_of(input int s);
    logic [27:0] t [12] = '{28'h9400000, 28'h9420000, 28'h9600000, 28'h9620000,
                            28'h9640000, 28'h9660000, 28'h9680000, 28'h96A0000,
                            28'h96C0000, 28'h9880000, 28'h9860000, 28'h9C00000};
    return t[s];
  endfunction

  function automatic logic [27:0] key_addr(input int s);
    logic [27:0] t [4] = '{28'h9FE0000, 28'h8000000, 28'h8020000, 28'h8040000};
    return t[s];
  endfunction

  function automatic logic [15:0] key_data(input int s);
    return (s == 0 || s == 2) ? 16'hD200 : 16'h1500;
  endfunction

  task automatic model_reset();
    foreach (m_reg[i]) m_reg[i] = '0;
    m_step = 0; m_unl = 0; m_pulse = 0; m_dir = 0; m_blk = 0;
  endtask

  task automatic model_write(input logic [27:0] a, input logic [15:0] d);
    int  s;
    bit  cur_ok, first_ok, done, lock;
    s = slot_of(a);
    m_pulse = m_unl && (s == 4);
    m_dir   = m_pulse && d[15];
    m_blk   = 0;
    if (m_pulse) m_blk = (int'(d[14:0]) > 4) ? 4 : int'(d[14:0]);
    if (m_unl && s >= 0) m_reg[s] = d;
    cur_ok   = (a == key_addr(m_step)) && (d == key_data(m_step));
    first_ok = (a == key_addr(0)) && (d == key_data(0));
    done     = cur_ok && (m_step == 3);
    lock     = (a == 28'h9FC0000) && (d == 16'h1500);
    if (cur_ok)        m_step = done ? 0 : m_step + 1;
    else if (first_ok) m_step = 1;
    else               m_step = 0;
    if (lock)      m_unl = 0;
    else if (done) m_unl = 1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag,  "unlocked",      32'(unlocked),      32'(m_unl));
    chk(tag,  "card_ctrl",     32'(card_ctrl),     32'(m_reg[0]));
    chk(tag,  "buf_ctrl",      32'(buf_ctrl),      32'(m_reg[1]));
    chk(tag,  "block_ctrl",    32'(block_ctrl),    32'(m_reg[4]));
    chk(tag,  "spi_ctrl",      32'(spi_ctrl),      32'(m_reg[5]));
    chk(tag,  "spi_wr_ctrl",   32'(spi_wr_ctrl),   32'(m_reg[6]));
    chk(tag,  "rtc_ctrl",      32'(rtc_ctrl),      32'(m_reg[7]));
    chk(tag,  "autosave_ctrl", 32'(autosave_ctrl), 32'(m_reg[8]));
    chk(tag,  "rom_page",      32'(rom_page),      32'(m_reg[9]));
    chk(tag,  "psram_page",    32'(psram_page),    32'(m_reg[10]));
    chk(tag,  "ram_page",      32'(ram_page),      32'(m_reg[11]));
    chk("R7", "sector_addr",   sector_addr,        {m_reg[3], m_reg[2]});
    chk("R9", "card_on",       32'(card_on),       32'((m_reg[0] == 1) || (m_reg[0] == 3)));
    chk("R9", "card_read",     32'(card_read_state), 32'(m_reg[0] == 3));
    chk("R8", "start_pulse",   32'(start_pulse),   32'(m_pulse));
    chk("R8", "start_write",   32'(start_write),   32'(m_dir));
    chk("R8", "start_blocks",  32'(start_blocks),  32'(m_blk));
  endtask

  // called at a negedge; returns at the next negedge with results settled
  task automatic do_write(input logic [27:0] a, input logic [15:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    wr_en = 1'b0;
    m_pulse = 0; m_dir = 0; m_blk = 0;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic unlock_all(input string tag);
    for (int k = 0; k < 4; k++) do_write(key_addr(k), key_data(k), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");

    // locked writes are dropped
    do_write(28'h9880000, 16'h1234, "R4");
    do_write(28'h9400000, 16'h0001, "R4");

    // broken order: steps 1,2 then wrong data on step 3, then step 4
    do_write(key_addr(0), key_data(0), "R3");
    do_write(key_addr(1), key_data(1), "R3");
    do_write(key_addr(2), 16'h0000, "R3");
    do_write(key_addr(3), key_data(3), "R3");
    do_write(28'h9880000, 16'h00AA, "R3");
    // a repeated first step restarts at step two
    do_write(key_addr(0), key_data(0), "R3");
    unlock_all("R3");
    idle("R2");

    // every register, several writes in one window
    for (int s = 0; s < 12; s++) do_write(addr_of(s), 16'(16'hA100 + s), "R5");
    do_write(28'h9600000, 16'hBEEF, "R7");
    do_write(28'h9620000, 16'h0123, "R7");

    // block count: write direction, clamp, back to back, zero
    do_write(28'h9640000, 16'h8003, "R8");
    idle("R8");
    do_write(28'h9640000, 16'h0007, "R8");
    do_write(28'h9640000, 16'hFFFF, "R8");
    do_write(28'h9640000, 16'h0000, "R8");
    idle("R8");

    // card control decode
    do_write(28'h9400000, 16'h0002, "R9");
    do_write(28'h9400000, 16'h0003, "R9");
    do_write(28'h9400000, 16'h0001, "R9");
    do_write(28'h9400000, 16'h0000, "R9");

    // unmapped addresses and near-miss lock
    do_write(28'h9500000, 16'h5555, "R10");
    do_write(28'h9400002, 16'h5555, "R10");
    do_write(28'h9FC0000, 16'h1501, "R6");
    do_write(28'h9880000, 16'h0042, "R6");

    // lock, then writes are ignored
    do_write(28'h9FC0000, 16'h1500, "R6");
    do_write(28'h9880000, 16'h0099, "R6");
    do_write(28'h9640000, 16'h0002, "R6");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8) unlock_all("R2");
      else if (r < 14) do_write(28'h9FC0000, 16'h1500, "R6");
      else if (r < 22) begin
        int k;
        k = int'($urandom_range(0, 3));
        do_write(key_addr(k), ($urandom_range(0, 3) == 0) ? 16'($urandom) : key_data(k), "R3");
      end
      else if (r < 75) do_write(addr_of(int'($urandom_range(0, 11))), 16'($urandom), "R5");
      else if (r < 85) idle("R8");
      else do_write(28'($urandom), 16'($urandom), "R10");
    end
    idle("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule